// File: doc/BRIEF.md
# Per-Lane Recirculating Instruction Line Buffer

This block stores a fixed set of 16-byte instruction lines. Each byte position is its own lane, and each lane is an independent queue of 11-bit entries. An entry holds one instruction byte and three flag bits: the byte is in use, the byte starts a branch predicted taken, and the byte is a branch destination. A test or bring-up harness fills the buffer through a serial load port that takes one entry per clock. A start pulse then hands the lanes to sixteen downstream byte consumers.

Each lane has its own valid/ready handshake and moves to its next entry without waiting for the others. One byte column can therefore work on the following line while its neighbours are still on the current one. The replay input chooses how a lane behaves after its last stored entry. In cyclic mode it returns to entry 0, so the stored lines repeat for as long as the consumers run. In single-pass mode the lane goes idle.

Top module: `line_lane_fifo`

## Requirements
- R1: After reset, `loaded` is 0 and every bit of `lane_valid` is 0.
- R2: Each 11-bit entry is laid out as bits [7:0] instruction byte, bit 8 used flag, bit 9 branch-start flag, bit 10 branch-target flag. An entry is presented on its lane's slice `lane_entry[11*i+10 : 11*i]` exactly as it was loaded.
- R3: The serial load port stores the k-th accepted entry (k counted from 0) into lane k / DEPTH at position k % DEPTH. One entry is stored per clock while `load_en` is high.
- R4: `loaded` rises in the cycle after the DEPTH×16-th entry is accepted and then stays high. Once it is high, `load_en` has no effect on the stored contents.
- R5: A `start` pulse seen while `loaded` is 0 has no effect. This includes a pulse in the same cycle as the final load entry. Every `lane_valid` bit stays 0.
- R6: A `start` pulse while `loaded` is 1 raises all lane valids in the next cycle. Every lane presents its position-0 entry, so consumption begins at line 0.
- R7: A lane moves to its next position only on a clock where its own valid and ready are both 1. The other lanes are not affected.
- R8: With `replay` = 1, a lane that pops its last position (DEPTH-1) returns to position 0 and stays valid.
- R9: With `replay` = 0, a lane that pops its last position drops its valid and keeps it low.
- R10: Asserting a lane's ready while its valid is 0 changes neither its position nor its valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Serial load strobe, one entry per clock |
| load_entry | input | 11 | Entry to store (layout as in R2) |
| loaded | output | 1 | All DEPTH×16 entries have been stored |
| start | input | 1 | Pulse that releases the lanes once loaded |
| replay | input | 1 | 1: cyclic read, 0: single pass |
| lane_ready | input | 16 | Per-lane consumer ready |
| lane_valid | output | 16 | Per-lane entry available |
| lane_entry | output | 176 | Per-lane current entry, 11 bits per lane |

## Verification
Two functions can fall in the same clock: the final serial load entry and the start pulse. The bench drives both in the same cycle. It then judges that `loaded` rises while every valid stays low, because the release needs `loaded` to be high already. The bench also pops several lanes in one cycle, some of them at their wrap point and one already spent. A per-lane position model built from the requirements judges that each lane's entry, valid and wrap depend only on its own handshake.

// File: rtl/line_fifo_pkg.sv
`timescale 1ns/1ps
package line_fifo_pkg;
    localparam int ENTRY_W = 11;

    typedef struct packed {
        logic       tgt;     // bit 10: branch destination
        logic       brs;     // bit 9: start of predicted-taken branch
        logic       used;    // bit 8: byte in use
        logic [7:0] code;    // bits 7:0: instruction byte
    } lane_entry_t;
endpackage

// File: rtl/line_fifo_loader.sv
`timescale 1ns/1ps
module line_fifo_loader #(
    parameter int LANES = 16,
    parameter int DEPTH = 8,
    localparam int TOTAL  = LANES * DEPTH,
    localparam int CNT_W  = $clog2(TOTAL + 1),
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en_i,
    input  logic              start_i,
    output logic              wr_en_o,
    output logic [LANE_W-1:0] wr_lane_o,
    output logic [PTR_W-1:0]  wr_idx_o,
    output logic              loaded_o,
    output logic              run_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             loaded;
        logic             run;
    } ld_state_t;

    ld_state_t s_d, s_q;
    logic [CNT_W-1:0] lane_sel, pos_sel;

    always_comb begin
        s_d      = s_q;
        lane_sel = s_q.cnt / CNT_W'(DEPTH);
        pos_sel  = s_q.cnt % CNT_W'(DEPTH);
        wr_en_o  = load_en_i && !s_q.loaded;
        if (wr_en_o) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == CNT_W'(TOTAL - 1)) s_d.loaded = 1'b1;
        end
        if (start_i && s_q.loaded) s_d.run = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_lane_o = lane_sel[LANE_W-1:0];
    assign wr_idx_o  = pos_sel[PTR_W-1:0];
    assign loaded_o  = s_q.loaded;
    assign run_o     = s_q.run;

    AST_LOADED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_o |=> loaded_o);                                          // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(TOTAL));                                       // R4
    AST_NO_WRITE_WHEN_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_o |-> !wr_en_o);                                          // R4
    AST_RUN_NEEDS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> $past(loaded_o));                               // R5
endmodule

// File: rtl/line_fifo_lane.sv
`timescale 1ns/1ps
module line_fifo_lane
    import line_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  lane_entry_t      wr_entry_i,
    input  logic             run_i,
    input  logic             replay_i,
    input  logic             ready_i,
    output logic             valid_o,
    output lane_entry_t      entry_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        lane_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]        rd_ptr;
        logic                    spent;
    } lane_state_t;

    lane_state_t s_d, s_q;
    logic        pop;

    assign valid_o = run_i && !s_q.spent;
    assign entry_o = s_q.mem[s_q.rd_ptr];
    assign pop     = valid_o && ready_i;

    always_comb begin
        s_d = s_q;
        if (wr_en_i) s_d.mem[wr_idx_i] = wr_entry_i;
        if (pop) begin
            if (s_q.rd_ptr == LAST) begin
                if (replay_i) s_d.rd_ptr = '0;
                else          s_d.spent  = 1'b1;
            end else begin
                s_d.rd_ptr = s_q.rd_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_PTR_ONLY_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && ready_i) |=> $stable(s_q.rd_ptr));                  // R7
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && s_q.rd_ptr == LAST && replay_i)
        |=> (valid_o && s_q.rd_ptr == '0));                              // R8
    AST_SINGLE_PASS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && s_q.rd_ptr == LAST && !replay_i) |=> !valid_o); // R9
    AST_IDLE_READY_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && ready_i) |=> (!valid_o || $rose(run_i)));          // R10
endmodule

// File: rtl/line_lane_fifo.sv
`timescale 1ns/1ps
module line_lane_fifo
    import line_fifo_pkg::*;
#(
    parameter int LANES = 16,
    parameter int DEPTH = 8,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic [ENTRY_W-1:0]         load_entry,
    output logic                       loaded,
    input  logic                       start,
    input  logic                       replay,
    input  logic [LANES-1:0]           lane_ready,
    output logic [LANES-1:0]           lane_valid,
    output logic [LANES*ENTRY_W-1:0]   lane_entry
);
    logic              wr_en;
    logic [LANE_W-1:0] wr_lane;
    logic [PTR_W-1:0]  wr_idx;
    logic              run;
    lane_entry_t       in_entry;

    assign in_entry = lane_entry_t'(load_entry);

    line_fifo_loader #(.LANES(LANES), .DEPTH(DEPTH)) i_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en_i (load_en),
        .start_i   (start),
        .wr_en_o   (wr_en),
        .wr_lane_o (wr_lane),
        .wr_idx_o  (wr_idx),
        .loaded_o  (loaded),
        .run_o     (run)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_entry_t out_entry;
        logic        lane_wr;

        assign lane_wr = wr_en && (wr_lane == LANE_W'(g));

        line_fifo_lane #(.DEPTH(DEPTH)) i_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en_i    (lane_wr),
            .wr_idx_i   (wr_idx),
            .wr_entry_i (in_entry),
            .run_i      (run),
            .replay_i   (replay),
            .ready_i    (lane_ready[g]),
            .valid_o    (lane_valid[g]),
            .entry_o    (out_entry)
        );

        assign lane_entry[g*ENTRY_W +: ENTRY_W] = out_entry;
    end

    AST_IDLE_BEFORE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> (lane_valid == '0));                                 // R5
    AST_ALL_VALID_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && loaded && lane_valid == '0 && !$past(run)) |=> (lane_valid == '1)); // R6
endmodule

// File: tb/test_line_lane_fifo.sv
`timescale 1ns/1ps
module test_line_lane_fifo;
    localparam int LANES = 16;
    localparam int DEPTH = 8;
    localparam int EW    = 11;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  load_en = 1'b0;
    logic [EW-1:0]         load_entry = '0;
    logic                  loaded;
    logic                  start = 1'b0;
    logic                  replay = 1'b0;
    logic [LANES-1:0]      lane_ready = '0;
    logic [LANES-1:0]      lane_valid;
    logic [LANES*EW-1:0]   lane_entry;

    int checks = 0;
    int errors = 0;
    int m_pos  [LANES];
    bit m_done [LANES];
    bit m_run = 1'b0;

    always #2.5 clk = ~clk;

    line_lane_fifo #(.LANES(LANES), .DEPTH(DEPTH)) i_line_lane_fifo (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_entry(load_entry),
        .loaded(loaded), .start(start), .replay(replay),
        .lane_ready(lane_ready), .lane_valid(lane_valid), .lane_entry(lane_entry)
    );

    // Layout per R2: {tgt, brs, used, byte}
    function automatic logic [EW-1:0] pat(int k);
        logic [7:0] b;
        b = 8'((k * 37 + 11) & 255);
        return {(k % 11) == 4, (k % 7) == 3, (k % 5) != 0, b};
    endfunction

    task automatic check_loaded(string tag, logic exp);
        checks++;
        if (loaded !== exp) begin
            errors++;
            $display("FAIL %s loaded=%0b expected=%0b", tag, loaded, exp);
        end
    endtask

    task automatic check_all(string tag);
        bit bad = 0;
        checks++;
        for (int l = 0; l < LANES; l++) begin
            logic          ev;
            logic [EW-1:0] ee;
            logic [EW-1:0] ae;
            ev = m_run && !m_done[l];
            ee = pat(l * DEPTH + m_pos[l]);
            ae = lane_entry[l*EW +: EW];
            if (lane_valid[l] !== ev || (ev && ae !== ee)) begin
                bad = 1;
                $display("FAIL %s lane %0d valid=%0b expected=%0b entry=%h expected=%h",
                         tag, l, lane_valid[l], ev, ae, ee);
            end
        end
        if (bad) errors++;
    endtask

    task automatic pop(logic [LANES-1:0] mask);
        @(negedge clk);
        lane_ready = mask;
        @(negedge clk);
        lane_ready = '0;
        for (int l = 0; l < LANES; l++) begin
            if (mask[l] && m_run && !m_done[l]) begin
                if (m_pos[l] == DEPTH - 1) begin
                    if (replay) m_pos[l] = 0;
                    else        m_done[l] = 1;
                end else begin
                    m_pos[l]++;
                end
            end
        end
    endtask

    task automatic t_reset;
        for (int l = 0; l < LANES; l++) begin m_pos[l] = 0; m_done[l] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_loaded("R1", 1'b0);
        check_all("R1");
    endtask

    task automatic t_early_start;
        @(negedge clk);
        start = 1'b1;
        lane_ready = '1;
        @(negedge clk);
        start = 1'b0;
        lane_ready = '0;
        check_all("R5 early start");
        check_all("R10 ready while idle");
    endtask

    task automatic t_load_with_start_on_last;
        for (int k = 0; k < LANES * DEPTH; k++) begin
            @(negedge clk);
            load_en = 1'b1;
            load_entry = pat(k);
            start = (k == LANES * DEPTH - 1);
            if (k == LANES * DEPTH - 2) check_loaded("R4 not yet", 1'b0);
        end
        @(negedge clk);
        load_en = 1'b0;
        start = 1'b0;
        check_loaded("R4", 1'b1);
        check_all("R5 start with last entry");
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            load_en = 1'b1;
            load_entry = 11'h7FF;
        end
        @(negedge clk);
        load_en = 1'b0;
        check_loaded("R4 holds", 1'b1);
    endtask

    task automatic t_release;
        replay = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_run = 1'b1;
        check_all("R6 R3 R2 release");
    endtask

    task automatic t_independent;
        pop(16'h0001);
        pop(16'h0001);
        check_all("R7 lane 0 only");
        pop(16'h0090);
        check_all("R7 lanes 4 7");
    endtask

    task automatic t_single_pass;
        for (int i = 0; i < DEPTH; i++) pop(16'h0008);
        check_all("R9 lane 3 spent");
        pop(16'h0008);
        pop(16'h0008);
        check_all("R10 spent lane ready");
    endtask

    task automatic t_replay;
        replay = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            pop(16'h0020);
            check_all("R8 R3 lane 5 walk");
        end
        for (int i = 0; i < DEPTH + 3; i++) begin
            pop('1);
            check_all("R8 R7 R10 all lanes");
        end
    endtask

    initial begin
        #(5ns * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_early_start();
        t_load_with_start_on_last();
        t_release();
        t_independent();
        t_single_pass();
        t_replay();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule